// File: doc/BRIEF.md
# Auxiliary System-Control Register Block

This block is a small memory-mapped peripheral for a workstation I/O controller. It holds five byte-wide control registers: configuration, diagnostic, modem control, auxiliary-1 (miscellaneous functions) and auxiliary-2 (software power-down). It also holds a 16-bit LED register and a system-control register that is accessed as a 32-bit word. A simple register bus reaches the registers. Each access carries a register select code, a write enable, an access size, an offset and write data. Read data comes back one cycle after the read strobe.

Several writes have side effects beyond storing a value:
- Writing auxiliary-1 with the terminal-count command bit gives a one-cycle pulse for the floppy controller. That bit is not stored.
- Writing auxiliary-2 with the power-off bit gives a one-cycle shutdown request.
- Writing the system-control register with its reset command gives a one-cycle system reset request and latches a reset-status flag.

The power-fail input is synchronized and gated by an enable bit in the configuration register. It drives a power-fail status bit in auxiliary-2 and an interrupt output. Software clears the status bit by writing a dedicated clear bit.

There are two resets. The soft reset clears only some of the registers, so the diagnostic, LED and system-control registers (including the reset-status flag) survive it. A separate power-on reset clears everything.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `irq` is high exactly when the power-fail status (auxiliary-2 bit 5, mask 0x20) and the power-fail interrupt enable (configuration bit 3, mask 0x08) are both set.
- R2: `pfail_in` passes through a two-flop synchronizer. In every cycle without an accepted auxiliary-2 write, the status bit is loaded with (synchronized level AND current enable). A change on `pfail_in` before clock edge k therefore shows in the status after edge k+2.
- R3: An accepted auxiliary-2 write keeps only data bits 0 (power-off) and 1 (clear). It keeps the current status bit unless bit 1 is one, in which case the status is cleared. Bit 1 is never stored, and readback is {status at bit 5, power-off at bit 0}.
- R4: An accepted auxiliary-2 write with data bit 0 set drives `shutdown_req` high in that same cycle only.
- R5: An accepted auxiliary-1 write with data bit 1 set drives `tc_pulse` high in that same cycle only. The stored value is the written byte with bit 1 cleared.
- R6: While `rst_n` is low, the configuration, auxiliary-1, auxiliary-2 (including status) and modem registers clear. The diagnostic, LED and system-control registers keep their values, and all bus accesses are ignored.
- R7: While `por_n` is low, every register, the synchronizer and `bus_rdata` are zero.
- R8: An accepted system-control write with data bit 0 set loads the register with 0x02 and drives `reset_req` high in that cycle. A write with bit 0 clear leaves the register unchanged.
- R9: `bus_rdata` holds the zero-extended register value in the cycle after an accepted read, and zero after any other cycle. A read returns the value from before any write in the same cycle.
- R10: Select codes are 0 configuration, 1 diagnostic, 2 modem, 3 auxiliary-1, 4 auxiliary-2, 5 LED and 6 system-control; code 7 selects nothing. Size codes are 0 byte, 1 half-word and 2 word. Byte registers accept size 0 only, LED size 1 only and system-control size 2 only, and all of them accept offset 0 only. Any other access is ignored: it reads zero, writes nothing and gives no pulse.
- R11: The configuration, diagnostic, modem (8-bit) and LED (16-bit) registers store written data unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous soft reset, active low |
| bus_req | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 3 | Register select code |
| bus_size | input | 2 | Access size code |
| bus_off | input | 2 | Offset within the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| pfail_in | input | 1 | Asynchronous power-fail indication |
| irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Floppy terminal-count pulse |
| shutdown_req | output | 1 | Shutdown request pulse |
| reset_req | output | 1 | System reset request pulse |

## Verification
The bench targets the following corner cases:
- **Clear racing a live failure.** A clear is written to auxiliary-2 while the power-fail input is still asserted. The status must drop for one cycle and then return. A design that lets the input win over the write would never show the drop, and one that makes the clear sticky would lose the later re-assertion.
- **Command bits must not be stored.** It writes the terminal-count bit and checks that it reads back as zero. A design that stored the bit would read back 0xFF instead of 0xFD.
- **Wrong size or nonzero offset.** These accesses must write nothing and give no pulse. A loose size decode would corrupt registers or issue spurious reset requests.
- **Soft reset is selective.** It checks which registers survive a soft reset and that the reset-status flag persists. A design that cleared too much would lose the diagnostic value and the 0x02 flag.

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs #(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [2:0]        bus_sel,
  input  logic [1:0]        bus_size,
  input  logic [1:0]        bus_off,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pfail_in,
  output logic              irq,
  output logic              tc_pulse,
  output logic              shutdown_req,
  output logic              reset_req
);
  localparam logic [2:0] S_CFG = 3'd0, S_DIAG = 3'd1, S_MDM = 3'd2, S_AUX1 = 3'd3,
                         S_AUX2 = 3'd4, S_LED = 3'd5, S_SYS = 3'd6;
  localparam logic [1:0] Z_BYTE = 2'd0, Z_HALF = 2'd1, Z_WORD = 2'd2;
  localparam int EN_BIT = 3, ST_BIT = 5, TC_BIT = 1, OFF_BIT = 0, CLR_BIT = 1, RST_BIT = 0;

  logic [7:0]        cfg_q, diag_q, mdm_q, aux1_q, sys_q;
  logic              pf_st, aux2_off;
  logic [LED_W-1:0]  led_q;
  logic [SYNC_N-1:0] pf_sync;
  logic              size_ok, acc, wr, rd;
  logic [DATA_W-1:0] rmux;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:LED_W];

  always_comb begin
    unique case (bus_sel)
      S_CFG, S_DIAG, S_MDM, S_AUX1, S_AUX2: size_ok = (bus_size == Z_BYTE);
      S_LED:                                size_ok = (bus_size == Z_HALF);
      S_SYS:                                size_ok = (bus_size == Z_WORD);
      default:                              size_ok = 1'b0;
    endcase
  end

  assign acc = bus_req && rst_n && (bus_off == 2'd0) && size_ok;
  assign wr  = acc && bus_we;
  assign rd  = acc && !bus_we;

  assign tc_pulse     = wr && (bus_sel == S_AUX1) && bus_wdata[TC_BIT];
  assign shutdown_req = wr && (bus_sel == S_AUX2) && bus_wdata[OFF_BIT];
  assign reset_req    = wr && (bus_sel == S_SYS)  && bus_wdata[RST_BIT];
  assign irq          = pf_st && cfg_q[EN_BIT];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) pf_sync <= '0;
    else        pf_sync <= {pf_sync[SYNC_N-2:0], pfail_in};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q <= '0; diag_q <= '0; mdm_q <= '0; aux1_q <= '0; sys_q <= '0;
      pf_st <= 1'b0; aux2_off <= 1'b0; led_q <= '0;
    end else if (!rst_n) begin
      cfg_q <= '0; mdm_q <= '0; aux1_q <= '0;
      pf_st <= 1'b0; aux2_off <= 1'b0;
    end else begin
      if (wr && bus_sel == S_AUX2) begin
        aux2_off <= bus_wdata[OFF_BIT];
        pf_st    <= pf_st && !bus_wdata[CLR_BIT];
      end else begin
        pf_st    <= pf_sync[SYNC_N-1] && cfg_q[EN_BIT];
      end
      if (wr) begin
        unique case (bus_sel)
          S_CFG:  cfg_q  <= bus_wdata[7:0];
          S_DIAG: diag_q <= bus_wdata[7:0];
          S_MDM:  mdm_q  <= bus_wdata[7:0];
          S_AUX1: aux1_q <= bus_wdata[7:0] & ~(8'd1 << TC_BIT);
          S_LED:  led_q  <= bus_wdata[LED_W-1:0];
          S_SYS:  if (bus_wdata[RST_BIT]) sys_q <= 8'h02;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rmux = '0;
    unique case (bus_sel)
      S_CFG:  rmux[7:0] = cfg_q;
      S_DIAG: rmux[7:0] = diag_q;
      S_MDM:  rmux[7:0] = mdm_q;
      S_AUX1: rmux[7:0] = aux1_q;
      S_AUX2: begin rmux[ST_BIT] = pf_st; rmux[OFF_BIT] = aux2_off; end
      S_LED:  rmux[LED_W-1:0] = led_q;
      S_SYS:  rmux[7:0] = sys_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) bus_rdata <= '0;
    else        bus_rdata <= rd ? rmux : '0;
endmodule

module aux_sysctl_chk (
  input logic        clk,
  input logic        por_n,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic [2:0]  bus_sel,
  input logic [1:0]  bus_size,
  input logic [1:0]  bus_off,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic        tc_pulse,
  input logic        shutdown_req,
  input logic        reset_req,
  input logic [7:0]  cfg_q,
  input logic [7:0]  diag_q,
  input logic [7:0]  aux1_q,
  input logic [7:0]  sys_q,
  input logic        pf_st
);
  // R5
  tc_only_on_aux1_chk: assert property (@(posedge clk) disable iff (!por_n)
    tc_pulse |-> (bus_req && bus_we && rst_n && bus_sel == 3'd3 && bus_size == 2'd0 &&
                  bus_off == 2'd0 && bus_wdata[1]));
  // R5
  tc_not_stored_chk: assert property (@(posedge clk) disable iff (!por_n)
    tc_pulse |=> !aux1_q[1]);
  // R3
  pf_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bus_req && bus_we && rst_n && bus_sel == 3'd4 && bus_size == 2'd0 && bus_off == 2'd0 &&
     bus_wdata[1]) |=> !irq);
  // R6
  soft_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> ($stable(diag_q) && $stable(sys_q)));
  // R6
  soft_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> (cfg_q == 8'h00 && aux1_q == 8'h00 && !pf_st));
  // R8
  sysreset_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    reset_req |=> (sys_q == 8'h02));
  // R4
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({tc_pulse, shutdown_req, reset_req}));
  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!bus_req || bus_we || !rst_n) |=> (bus_rdata == 32'd0));
endmodule

bind aux_sysctl_regs aux_sysctl_chk u_chk (.*);

// File: tb/sim_aux_sysctl_regs.sv
module sim_aux_sysctl_regs;
  logic clk = 0, por_n = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0, pfail_in = 0;
  logic [2:0] bus_sel = 0;
  logic [1:0] bus_size = 0, bus_off = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq, tc_pulse, shutdown_req, reset_req;

  aux_sysctl_regs u0 (.*);

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  string cur_req = "R7";
  bit done = 0;

  // reference state
  logic [7:0] m_cfg, m_diag, m_mdm, m_aux1, m_sys;
  logic m_st, m_off;
  logic [15:0] m_led;
  logic [31:0] m_rd;
  bit pf_hist[$];

  function automatic bit size_fits(logic [2:0] s, logic [1:0] z);
    if (s <= 3'd4) return z == 2'd0;
    if (s == 3'd5) return z == 2'd1;
    if (s == 3'd6) return z == 2'd2;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(logic [2:0] s);
    case (s)
      3'd0: return {24'd0, m_cfg};
      3'd1: return {24'd0, m_diag};
      3'd2: return {24'd0, m_mdm};
      3'd3: return {24'd0, m_aux1};
      3'd4: return {26'd0, m_st, 4'd0, m_off};
      3'd5: return {16'd0, m_led};
      3'd6: return {24'd0, m_sys};
      default: return 32'd0;
    endcase
  endfunction

  task automatic compare(string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %h expected %h", cur_req, what, $time, act, exp);
    end
  endtask

  task automatic model_clear_all();
    m_cfg = 0; m_diag = 0; m_mdm = 0; m_aux1 = 0; m_sys = 0;
    m_st = 0; m_off = 0; m_led = 0; m_rd = 0;
    pf_hist = '{0, 0};
  endtask

  task automatic cyc(bit p, bit r, bit req, bit we, logic [2:0] sel, logic [1:0] sz,
                     logic [1:0] off, logic [31:0] wd, bit pf);
    bit ok, w, rdx, synced, st_n;
    logic [31:0] rd_n;
    por_n = p; rst_n = r; bus_req = req; bus_we = we; bus_sel = sel;
    bus_size = sz; bus_off = off; bus_wdata = wd; pfail_in = pf;
    #1;
    if (!p) model_clear_all();
    ok = p && r && req && off == 2'd0 && size_fits(sel, sz);
    w = ok && we;
    rdx = ok && !we;
    vectors++;
    compare("irq", irq, m_st && m_cfg[3]);
    compare("tc_pulse", tc_pulse, w && sel == 3'd3 && wd[1]);
    compare("shutdown_req", shutdown_req, w && sel == 3'd4 && wd[0]);
    compare("reset_req", reset_req, w && sel == 3'd6 && wd[0]);
    compare("bus_rdata", bus_rdata, m_rd);
    if (p) begin
      synced = pf_hist[0];
      void'(pf_hist.pop_front());
      pf_hist.push_back(pf);
      rd_n = rdx ? model_read(sel) : 32'd0;
      if (!r) begin
        m_cfg = 0; m_mdm = 0; m_aux1 = 0; st_n = 0; m_off = 0;
      end else begin
        if (w && sel == 3'd4) st_n = m_st && !wd[1];
        else st_n = synced && m_cfg[3];
        if (w) case (sel)
          3'd0: m_cfg = wd[7:0];
          3'd1: m_diag = wd[7:0];
          3'd2: m_mdm = wd[7:0];
          3'd3: m_aux1 = wd[7:0] & 8'hFD;
          3'd4: m_off = wd[0];
          3'd5: m_led = wd[15:0];
          3'd6: if (wd[0]) m_sys = 8'h02;
          default: ;
        endcase
      end
      m_st = st_n;
      m_rd = rd_n;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, bit pf = 0);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 0, 0, 0, 0, pf);
  endtask
  task automatic wr8(logic [2:0] s, logic [7:0] d, bit pf = 0);
    cyc(1, 1, 1, 1, s, 0, 0, {24'd0, d}, pf);
  endtask
  task automatic rd8(logic [2:0] s, bit pf = 0);
    cyc(1, 1, 1, 0, s, 0, 0, 0, pf);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, pf);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_clear_all();
    @(negedge clk);
    cur_req = "R7";
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(2);

    cur_req = "R11";
    wr8(0, 8'h5A); wr8(1, 8'hC3); wr8(2, 8'h99);
    rd8(0); rd8(1); rd8(2);
    cyc(1, 1, 1, 1, 5, 1, 0, 32'h1234BEEF, 0);
    cyc(1, 1, 1, 0, 5, 1, 0, 0, 0); idle(1);

    cur_req = "R10";
    cyc(1, 1, 1, 1, 1, 1, 0, 32'hFF, 0);
    cyc(1, 1, 1, 1, 1, 0, 2, 32'h11, 0);
    cyc(1, 1, 1, 0, 1, 2, 0, 0, 0);
    cyc(1, 1, 1, 0, 1, 0, 3, 0, 0);
    cyc(1, 1, 1, 1, 7, 0, 0, 32'hFF, 0);
    cyc(1, 1, 1, 1, 6, 0, 0, 32'h1, 0);
    cyc(1, 1, 1, 1, 3, 1, 0, 32'h2, 0);
    rd8(1);

    cur_req = "R9";
    wr8(1, 8'h3C);
    cyc(1, 1, 1, 0, 1, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 2, 0, 0, 0, 0);
    idle(1);

    cur_req = "R5";
    wr8(3, 8'hFF); rd8(3);
    wr8(3, 8'h40); rd8(3);

    cur_req = "R2";
    for (int i = 0; i < 5; i++) idle(1, 1);
    rd8(4, 1);
    cur_req = "R1";
    idle(2, 1);

    cur_req = "R3";
    wr8(4, 8'h02, 1);
    idle(3, 1);
    for (int i = 0; i < 4; i++) idle(1, 0);
    rd8(4);
    wr8(4, 8'hFC); rd8(4);

    cur_req = "R4";
    wr8(4, 8'h01); rd8(4);
    wr8(4, 8'h00);

    cur_req = "R1";
    wr8(0, 8'h00);
    idle(5, 1);
    rd8(4, 1);
    wr8(0, 8'h08, 1);
    idle(4, 1);
    wr8(0, 8'h00, 1);
    idle(2, 0);

    cur_req = "R8";
    cyc(1, 1, 1, 1, 6, 2, 0, 32'hFFFFFFFE, 0);
    cyc(1, 1, 1, 0, 6, 2, 0, 0, 0); idle(1);
    cyc(1, 1, 1, 1, 6, 2, 0, 32'h1, 0);
    cyc(1, 1, 1, 0, 6, 2, 0, 0, 0);
    cyc(1, 1, 1, 0, 6, 2, 2, 0, 0);
    idle(1);

    cur_req = "R6";
    wr8(0, 8'h08); wr8(2, 8'h77); wr8(3, 8'h81); wr8(1, 8'hA5);
    idle(4, 1);
    cyc(1, 0, 1, 1, 1, 0, 0, 32'h00, 1);
    cyc(1, 0, 1, 0, 1, 0, 0, 0, 1);
    for (int s = 0; s < 7; s++) begin
      cyc(1, 1, 1, 0, 3'(s), (s == 5) ? 2'd1 : (s == 6) ? 2'd2 : 2'd0, 0, 0, 1);
    end
    idle(1);

    cur_req = "R7";
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 1, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 6, 2, 0, 0, 0);
    idle(1);

    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      cyc(1, r > 2, $urandom_range(0, 3) != 0, $urandom_range(0, 1),
          3'($urandom_range(0, 7)), 2'($urandom_range(0, 2)),
          ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'd0,
          $urandom, (i / 37) % 2 == 1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule